// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a serial nonvolatile memory reached over three wires: a select line, a shift clock and a data input. A data output and its output enable go to a tri-state pad. The block runs on a fast system clock. It oversamples the select, shift clock and data input through a synchronizer and acts on each rising edge of the shift clock.

The storage is a 16384-bit array. A static organization input chooses its shape:
- 1024 words of 16 bits when the input is high.
- 2048 words of 8 bits when it is low.

The organization pad carries a weak pull-up, so an unconnected pin reads as high. The host can do four things: read a word and keep clocking to stream the following words, write a word, enable writes, and disable writes. A write replaces the old word directly. A busy period, whose length is a parameter in system clock cycles, follows each write. When the select line is raised again during or after that period, the output shows busy or ready.

Top module: `eep3w_slave`

## Requirements
- R1: With `org_x16`=1 the array is 1024 x 16 with 10 address bits. With `org_x16`=0 it is 2048 x 8 with 11 address bits. The 16-bit word a holds byte 2a in bits 15:8 and byte 2a+1 in bits 7:0.
- R2: A frame is a start bit 1, then a 2-bit opcode, then the address MSB first. The opcodes are 10 = read, 01 = write and 00 = extended group. Zeros on `sdin` before the start bit are ignored.
- R3: After the last address bit of a read, `sdout` drives a dummy 0. Each later rising shift-clock edge then presents the next data bit, MSB first.
- R4: While clocking continues, a read streams the following words with no new frame. The address wraps from the last word to word 0.
- R5: An extended frame whose two top address bits are 11 enables writes, and one whose top bits are 00 disables them. Reset leaves writes disabled.
- R6: A write frame sent while writes are disabled leaves the memory unchanged.
- R7: A complete write frame followed by a falling select, with writes enabled, replaces the addressed word with no prior erase. It starts a busy period of `BUSY_CYCLES` clocks.
- R8: Once a write has started, raising the select drives `sdout` to 0 while busy and to 1 when ready. Frames sent while busy are ignored.
- R9: `sdout_en` is 0 while the select is low. It is also 0 while the select is high and the block is neither sending read data nor showing status.
- R10: Dropping the select before the last data bit of a write abandons the frame, and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| org_x16 | input | 1 | Organization: 1 = 16-bit words, 0 = 8-bit words |
| sel | input | 1 | Device select, active high |
| sclk | input | 1 | Serial shift clock |
| sdin | input | 1 | Serial data input |
| sdout | output | 1 | Serial data or ready/busy value |
| sdout_en | output | 1 | Output enable for the data pad; 0 means high impedance |

## Verification
A wrong bit count or a stale opcode shows up on the first read after the fault. The dummy bit moves, or the word comes out shifted by one, within a single frame. A wrong write-enable latch or launch condition stays hidden until the affected word is read back, so every write is followed by a read of the same word, and in the other organization where aliasing applies. Busy-timer faults show up at the next raise of the select, through the status bit sampled early and again after `BUSY_CYCLES`.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_WDATA,
      ST_RDOUT,
      ST_DONE
   } eep3w_state_t;

   localparam logic [1:0] OPC_RD  = 2'b10;
   localparam logic [1:0] OPC_WR  = 2'b01;
   localparam logic [1:0] OPC_EXT = 2'b00;
   localparam logic [1:0] OPC_ER  = 2'b11;

   localparam logic [1:0] EXT_ENABLE  = 2'b11;
   localparam logic [1:0] EXT_DISABLE = 2'b00;

endpackage

// File: rtl/eep3w_sync.sv
module eep3w_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("eep3w_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic [W-1:0] flop_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flop_q <= '0;
            else        flop_q <= d;
         end
         assign q = flop_q;
      end else begin : g_chain
         localparam int CHW = STAGES * W;
         logic [CHW-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[CHW-W-1:0], d};
         end
         assign q = chain_q[CHW-1 -: W];
      end
   endgenerate

endmodule

// File: rtl/eep3w_timer.sv
module eep3w_timer #(
   parameter int BUSY_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int TW = $clog2(BUSY_CYCLES + 1);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad
         $error("eep3w_timer: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [TW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left_q <= '0;
      else if (start)        left_q <= TW'(BUSY_CYCLES);
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

   assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= TW'(BUSY_CYCLES));

endmodule

// File: rtl/eep3w_array.sv
module eep3w_array #(
   parameter int AW8 = 11
) (
   input  logic           clk,
   input  logic           x16,
   input  logic [AW8-1:0] raddr,
   output logic [15:0]    rdata,
   input  logic           we,
   input  logic [AW8-1:0] waddr,
   input  logic [15:0]    wdata
);

   localparam int DEPTH = 1 << AW8;

   logic [7:0] mem [DEPTH];

   logic [AW8-1:0] r_hi, r_lo, w_hi, w_lo;

   always_comb begin
      r_hi = x16 ? {raddr[AW8-2:0], 1'b0} : raddr;
      r_lo = {raddr[AW8-2:0], 1'b1};
      w_hi = x16 ? {waddr[AW8-2:0], 1'b0} : waddr;
      w_lo = {waddr[AW8-2:0], 1'b1};
      rdata = x16 ? {mem[r_hi], mem[r_lo]} : {8'h00, mem[r_hi]};
   end

   always_ff @(posedge clk) begin
      if (we) begin
         if (x16) begin
            mem[w_hi] <= wdata[15:8];
            mem[w_lo] <= wdata[7:0];
         end else begin
            mem[w_hi] <= wdata[7:0];
         end
      end
   end

endmodule

// File: rtl/eep3w_ctrl.sv
module eep3w_ctrl
   import eep3w_pkg::*;
#(
   parameter int AW8 = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           x16,
   input  logic           cs,
   input  logic           sk_rise,
   input  logic           di,
   input  logic           busy,
   input  logic [15:0]    rdata,
   output logic [AW8-1:0] addr,
   output logic [15:0]    wdata,
   output logic           we,
   output logic           sdo,
   output logic           sdo_en
);

   localparam int AW16 = AW8 - 1;
   localparam int CW   = 5;

   eep3w_state_t   state_q;
   logic [1:0]     opc_q;
   logic [AW8-1:0] addr_q;
   logic [15:0]    dat_q;
   logic [15:0]    shreg_q;
   logic [CW-1:0]  cnt_q;
   logic           dummy_q, ewen_q, stat_q, cs_q, we_q;

   logic [AW8-1:0] addr_in, addr_mask, addr_inc;
   logic [CW-1:0]  last_addr, last_dat;
   logic [1:0]     ext_sel;
   logic [15:0]    rd_word;
   logic           cs_fall;

   always_comb begin
      addr_in   = {addr_q[AW8-2:0], di};
      addr_mask = x16 ? {1'b0, {AW16{1'b1}}} : {AW8{1'b1}};
      addr_inc  = (addr_q + 1'b1) & addr_mask;
      last_addr = x16 ? CW'(AW16 - 1) : CW'(AW8 - 1);
      last_dat  = x16 ? CW'(15) : CW'(7);
      ext_sel   = x16 ? addr_in[AW16-1 -: 2] : addr_in[AW8-1 -: 2];
      rd_word   = x16 ? rdata : {rdata[7:0], 8'h00};
      cs_fall   = cs_q && !cs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         opc_q   <= '0;
         addr_q  <= '0;
         dat_q   <= '0;
         shreg_q <= '0;
         cnt_q   <= '0;
         dummy_q <= 1'b0;
         ewen_q  <= 1'b0;
         stat_q  <= 1'b0;
         cs_q    <= 1'b0;
         we_q    <= 1'b0;
      end else begin
         cs_q <= cs;
         we_q <= cs_fall && (state_q == ST_DONE) && (opc_q == OPC_WR) && ewen_q && !busy;
         if (we_q) stat_q <= 1'b1;
         if (!cs) begin
            state_q <= ST_IDLE;
            dummy_q <= 1'b0;
         end else if (sk_rise) begin
            case (state_q)
               ST_IDLE: begin
                  if (di && !busy) begin
                     state_q <= ST_OPC;
                     cnt_q   <= '0;
                     addr_q  <= '0;
                     stat_q  <= 1'b0;
                  end
               end
               ST_OPC: begin
                  opc_q <= {opc_q[0], di};
                  if (cnt_q == CW'(1)) begin
                     state_q <= ST_ADDR;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_ADDR: begin
                  addr_q <= addr_in & addr_mask;
                  if (cnt_q == last_addr) begin
                     cnt_q <= '0;
                     case (opc_q)
                        OPC_RD: begin
                           state_q <= ST_RDOUT;
                           dummy_q <= 1'b1;
                        end
                        OPC_WR: begin
                           state_q <= ST_WDATA;
                           dat_q   <= '0;
                        end
                        OPC_EXT: begin
                           if (ext_sel == EXT_ENABLE)       ewen_q <= 1'b1;
                           else if (ext_sel == EXT_DISABLE) ewen_q <= 1'b0;
                           state_q <= ST_DONE;
                        end
                        OPC_ER:  state_q <= ST_DONE;
                        default: state_q <= ST_DONE;
                     endcase
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_WDATA: begin
                  dat_q <= {dat_q[14:0], di};
                  if (cnt_q == last_dat) state_q <= ST_DONE;
                  else                   cnt_q   <= cnt_q + 1'b1;
               end
               ST_RDOUT: begin
                  if (dummy_q || cnt_q == last_dat) begin
                     shreg_q <= rd_word;
                     cnt_q   <= '0;
                     dummy_q <= 1'b0;
                  end else begin
                     shreg_q <= shreg_q << 1;
                     cnt_q   <= cnt_q + 1'b1;
                     if ((cnt_q + CW'(1)) == last_dat) addr_q <= addr_inc;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign addr   = addr_q;
   assign wdata  = dat_q;
   assign we     = we_q;
   assign sdo_en = cs && ((state_q == ST_RDOUT) || ((state_q == ST_IDLE) && stat_q));
   assign sdo    = (state_q == ST_RDOUT) ? (!dummy_q && shreg_q[15]) : !busy;

   assert_we_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> $past(ewen_q));

   assert_quiet_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !sdo_en);

   assert_dummy_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_en && state_q == ST_RDOUT && $past(state_q) != ST_RDOUT) |-> !sdo);

   assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && sk_rise && busy && state_q == ST_IDLE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave #(
   parameter int AW8         = 11,
   parameter int SYNC_STAGES = 2,
   parameter int BUSY_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic org_x16,
   input  logic sel,
   input  logic sclk,
   input  logic sdin,
   output logic sdout,
   output logic sdout_en
);

   generate
      if (AW8 < 3) begin : g_bad_aw
         $error("eep3w_slave: AW8 must be at least 3");
      end
   endgenerate

   logic [2:0]     pins_s;
   logic           cs_s, sk_s, di_s, sk_d, sk_rise, busy, we;
   logic [AW8-1:0] addr;
   logic [15:0]    rdata, wdata;

   eep3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sel, sclk, sdin}), .q(pins_s));

   assign {cs_s, sk_s, di_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_d <= 1'b0;
      else        sk_d <= sk_s;
   end
   assign sk_rise = sk_s && !sk_d;

   eep3w_ctrl #(.AW8(AW8)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .x16(org_x16), .cs(cs_s), .sk_rise(sk_rise),
      .di(di_s), .busy(busy), .rdata(rdata), .addr(addr), .wdata(wdata),
      .we(we), .sdo(sdout), .sdo_en(sdout_en));

   eep3w_array #(.AW8(AW8)) u_array (
      .clk(clk), .x16(org_x16), .raddr(addr), .rdata(rdata),
      .we(we), .waddr(addr), .wdata(wdata));

   eep3w_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(we), .busy(busy));

   assert_no_launch_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !we);

endmodule

// File: tb/test_eep3w_slave.sv
module test_eep3w_slave;

   localparam int CLK_PERIOD = 10;
   localparam int BUSY       = 300;

   logic clk = 1'b0, rst_n = 1'b0, org_x16 = 1'b1;
   logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0;
   logic sdout, sdout_en;
   int   n_run = 0, n_fail = 0;
   logic [7:0] mdl [2048];
   bit   ewen_exp = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eep3w_slave #(.BUSY_CYCLES(BUSY)) i_eep3w_slave (
      .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .sel(sel), .sclk(sclk),
      .sdin(sdin), .sdout(sdout), .sdout_en(sdout_en));

   task automatic w4(); repeat (4) @(negedge clk); endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      sdin = b; sclk = 1'b0; w4(); sclk = 1'b1; w4();
   endtask

   task automatic sel_on();
      @(negedge clk); sclk = 1'b0; sel = 1'b1; w4();
   endtask

   task automatic sel_off();
      sclk = 1'b0; sdin = 1'b0; sel = 1'b0; w4();
   endtask

   function automatic int awidth(); return org_x16 ? 10 : 11; endfunction
   function automatic int dwidth(); return org_x16 ? 16 : 8; endfunction

   function automatic logic [15:0] exp_word(input logic [10:0] a);
      if (org_x16) return {mdl[{a[9:0], 1'b0}], mdl[{a[9:0], 1'b1}]};
      return {8'h00, mdl[a]};
   endfunction

   task automatic send_head(input logic [1:0] op, input logic [10:0] a);
      send_bit(1'b1); send_bit(op[1]); send_bit(op[0]);
      for (int i = awidth() - 1; i >= 0; i--) send_bit(a[i]);
   endtask

   task automatic ext(input logic [1:0] top);
      logic [10:0] a;
      a = org_x16 ? {1'b0, top, 8'h00} : {top, 9'h000};
      sel_on(); send_head(2'b00, a); sel_off();
      if (top == 2'b11) ewen_exp = 1;
      if (top == 2'b00) ewen_exp = 0;
   endtask

   // full write; when the bench expects a launch, checks the status bit (R8)
   task automatic do_write(input logic [10:0] a, input logic [15:0] d, input string req);
      sel_on(); send_head(2'b01, a);
      for (int i = dwidth() - 1; i >= 0; i--) send_bit(d[i]);
      sel_off();
      if (ewen_exp) begin
         if (org_x16) begin
            mdl[{a[9:0], 1'b0}] = d[15:8]; mdl[{a[9:0], 1'b1}] = d[7:0];
         end else mdl[a] = d[7:0];
         sel_on();
         chk("R8", {req, " busy status"}, {sdout_en, sdout}, 2'b10);
         repeat (BUSY) @(negedge clk);
         chk("R8", {req, " ready status"}, {sdout_en, sdout}, 2'b11);
         sel_off();
      end
   endtask

   task automatic do_read(input logic [10:0] a, input int n, input int lead, input string req);
      logic [10:0] p;
      logic [15:0] w;
      p = a;
      sel_on();
      for (int i = 0; i < lead; i++) send_bit(1'b0);
      send_head(2'b10, a);
      sclk = 1'b0; w4();
      chk("R3", {req, " dummy bit"}, {sdout_en, sdout}, 2'b10);
      for (int k = 0; k < n; k++) begin
         w = '0;
         for (int b = 0; b < dwidth(); b++) begin
            sclk = 1'b1; w4(); sclk = 1'b0; w4();
            w = {w[14:0], sdout};
         end
         chk(req, $sformatf("word at %0d", p), w, exp_word(p));
         p = org_x16 ? ((p + 1) & 11'h3FF) : (p + 1);
      end
      sel_off();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed;
      logic [10:0] ra;
      logic [15:0] rd;
      seed = $urandom(32'h3A5C);
      repeat (5) @(negedge clk);
      chk("R9", "reset output enable", {31'b0, sdout_en}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R9: selected, idle, no status pending
      sel_on();
      chk("R9", "idle enable", {31'b0, sdout_en}, 0);
      sel_off();

      // R5 / R6: enable, write, disable, ignored write
      org_x16 = 1'b1;
      ext(2'b11);
      do_write(11'd5, 16'hA1B2, "R7");
      ext(2'b00);
      do_write(11'd5, 16'hFFFF, "R6");
      do_read(11'd5, 1, 0, "R6");
      sel_on();
      chk("R9", "idle after read", {31'b0, sdout_en}, 0);
      sel_off();

      // R1 aliasing between organizations
      ext(2'b11);
      do_write(11'd7, 16'hC3D4, "R1");
      org_x16 = 1'b0;
      do_read(11'd14, 2, 0, "R1");
      do_write(11'd20, 16'h005A, "R1");
      do_write(11'd21, 16'h0096, "R1");
      org_x16 = 1'b1;
      do_read(11'd10, 1, 0, "R1");

      // R4 sequential read with wrap in both organizations
      do_write(11'd1023, 16'h1357, "R4");
      do_write(11'd0, 16'h2468, "R4");
      do_read(11'd1023, 2, 0, "R4");
      org_x16 = 1'b0;
      do_write(11'd2047, 16'h00E7, "R4");
      do_read(11'd2047, 3, 0, "R4");

      // R2 leading zeros before start bit
      do_read(11'd14, 1, 3, "R2");
      org_x16 = 1'b1;

      // R8 frames while busy are ignored
      sel_on(); send_head(2'b01, 11'd9);
      for (int i = 15; i >= 0; i--) send_bit(1'b0);
      sel_off();
      mdl[18] = 8'h00; mdl[19] = 8'h00;
      sel_on();
      chk("R8", "busy before ignored frame", {sdout_en, sdout}, 2'b10);
      send_head(2'b01, 11'd9);
      for (int i = 15; i >= 0; i--) send_bit(1'b1);
      sel_off();
      repeat (BUSY) @(negedge clk);
      do_read(11'd9, 1, 0, "R8");

      // R10 truncated write frame
      sel_on(); send_head(2'b01, 11'd5);
      for (int i = 0; i < 15; i++) send_bit(1'b0);
      sel_off();
      repeat (BUSY) @(negedge clk);
      do_read(11'd5, 1, 0, "R10");

      // R5 reset clears the enable latch
      rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (3) @(negedge clk);
      ewen_exp = 0;
      do_write(11'd5, 16'h0F0F, "R5");
      do_read(11'd5, 1, 0, "R5");

      // constrained random writes and reads (R1, R3, R7)
      ext(2'b11);
      for (int it = 0; it < 12; it++) begin
         org_x16 = $urandom_range(1, 0);
         ra = org_x16 ? 11'($urandom_range(1023, 0)) : 11'($urandom_range(2047, 0));
         rd = 16'($urandom());
         if (!org_x16) rd[15:8] = 8'h00;
         do_write(ra, rd, "R7");
         do_read(ra, 1, 0, "R7");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule